// File: doc/BRIEF.md
# MDIO Management Master

This block runs management read and write transactions to an external Ethernet PHY over the two-wire management interface. A host presents one request. The request carries a read/write flag, a PHY address, a register address and, for a write, 16 bits of data. The block builds the management frame and divides its time-base clock down to produce MDC. It shifts the frame out on MDIO, then either keeps driving the write data or releases the line and collects the PHY's answer. The read result comes back together with a one-cycle completion pulse.

MDC toggles only while a transaction runs and is parked low at all other times. MDIO is modelled as three separate signals (drive value, drive enable and sampled input) so that the pad can live elsewhere. The division ratio is a parameter. Set it so that MDC sits near 2.5 MHz for the time base in use: with a 50 MHz time base a half period of 10 cycles gives 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: While a transaction runs, each MDC half period lasts exactly HALF_DIV time-base cycles, starting with a low half, and a transaction spans 64 full MDC periods.
- R2: When no transaction is in progress, MDC is low, the MDIO drive enable is low and the MDIO drive value is 0.
- R3: Each frame starts with 32 ones, then start code 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address and the 5-bit register address, each MSB first. Bit k of the frame (k = 0..63) is presented from the k-th MDC falling edge (bit 0 from acceptance) until the next falling edge.
- R4: A write drives the two turnaround bits as 1 then 0, followed by the 16 write-data bits MSB first, and keeps the drive enable high for all 64 bits.
- R5: A read drives the first 46 bits and holds the drive enable low for the two turnaround bits and the 16 data bits.
- R6: The MDIO drive value and drive enable change only in a cycle where MDC falls, or where busy rises or falls.
- R7: A read samples MDIO on the MDC rising edges of frame bits 48..63, MSB first, and the 16-bit result appears on rd_data in the cycle done is high. rd_data changes at no other time.
- R8: A request is accepted on a clock edge where req_valid is high and busy is low. From that edge busy is high for 128*HALF_DIV cycles. In the following cycle busy is low and done is high for exactly one cycle.
- R9: A request presented while busy is high is ignored: the running frame continues with the fields it was accepted with, and no transaction follows once req_valid has dropped.
- R10: A write transaction leaves rd_data unchanged.
- R11: While rst_n is low, MDC, drive enable, drive value, busy, done and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | PHY_AW | PHY address |
| req_reg | input | REG_AW | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Result of the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_in | input | 1 | Sampled MDIO line |

## Verification
Two events can fall in the same cycle: the done pulse that closes one transaction, and the acceptance of the next request, because busy is already low while done is high. The bench holds req_valid high from the middle of a read, with write fields applied, through the done cycle. It then expects the pending write to be accepted on the edge right after done. It also expects the read result to appear on rd_data in the done cycle and to stay intact while the new write runs. A cycle-by-cycle model built from the frame rules judges every output on every clock, including the release of the line at the turnaround.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned PRE_W = 32;
  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap    = run && (cnt_q == CNT_LAST);
  assign rise_ev = wrap && !mdc_q;
  assign fall_ev = wrap && mdc_q;
  assign mdc     = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (start) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else if (run) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R1: a rising and a falling MDC event never coincide
  assert_single_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
  parameter int unsigned FRAME_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       fall_ev,
  output logic                       start,
  output logic                       active,
  output logic                       done,
  output logic                       is_write,
  output logic                       last_bit,
  output logic [$clog2(FRAME_W)-1:0] bit_idx
);
  localparam int unsigned IW = $clog2(FRAME_W);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_W - 1);

  logic          active_q, active_d;
  logic          done_q, done_d;
  logic          wr_q, wr_d;
  logic [IW-1:0] idx_q, idx_d;

  assign start    = req_valid && !active_q;
  assign last_bit = (idx_q == IDX_LAST);
  assign active   = active_q;
  assign done     = done_q;
  assign is_write = wr_q;
  assign bit_idx  = idx_q;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    wr_d     = wr_q;
    done_d   = 1'b0;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      wr_d     = req_write;
    end else if (fall_ev) begin
      if (last_bit) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      wr_q     <= wr_d;
      idx_q    <= idx_d;
    end
  end

  // R9: a running transaction keeps its direction whatever req_valid does
  assert_hold_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !(fall_ev && last_bit)) |=> (active_q && $stable(wr_q)));

  // R8: done lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift #(
  parameter int unsigned FRAME_W = 64,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift_out,
  input  logic               shift_in,
  input  logic               capture,
  input  logic               mdio_in,
  output logic               tx_bit,
  output logic [DATA_W-1:0]  rd_data
);
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]  rx_q, rx_d;
  logic [DATA_W-1:0]  rd_q, rd_d;

  assign tx_bit  = tx_q[FRAME_W-1];
  assign rd_data = rd_q;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    rd_d = rd_q;
    if (load)
      tx_d = frame;
    else if (shift_out)
      tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    if (shift_in)
      rx_d = {rx_q[DATA_W-2:0], mdio_in};
    if (capture)
      rd_d = rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      rd_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
      rd_q <= rd_d;
    end
  end

  // R7: sampling and capturing are distinct MDC events
  assert_sample_vs_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_in && capture));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 10,
  parameter int unsigned PHY_AW   = 5,
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PHY_AW-1:0] req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int unsigned FRAME_W = PRE_W + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int unsigned IW      = $clog2(FRAME_W);
  localparam logic [IW-1:0] TA_IDX   = IW'(FRAME_W - DATA_W - 2);
  localparam logic [IW-1:0] DATA_IDX = IW'(FRAME_W - DATA_W);

  logic               start, active, is_write, last_bit;
  logic [IW-1:0]      bit_idx;
  logic               rise_ev, fall_ev, tx_bit;
  logic               sample_en;
  logic [1:0]         op_code, ta_code;
  logic [DATA_W-1:0]  data_fld;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    op_code  = req_write ? OP_WR : OP_RD;
    ta_code  = req_write ? TA_WR : 2'b00;
    data_fld = req_write ? req_wdata : '0;
  end
  assign frame = {{PRE_W{1'b1}}, SOF_CODE, op_code, req_phy, req_reg, ta_code, data_fld};

  mdio_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .fall_ev(fall_ev), .start(start), .active(active), .done(done),
    .is_write(is_write), .last_bit(last_bit), .bit_idx(bit_idx)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(active),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  assign sample_en = !is_write && (bit_idx >= DATA_IDX);

  mdio_shift #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .frame(frame),
    .shift_out(fall_ev), .shift_in(rise_ev && sample_en),
    .capture(fall_ev && last_bit && !is_write), .mdio_in(mdio_in),
    .tx_bit(tx_bit), .rd_data(rd_data)
  );

  assign busy     = active;
  assign mdio_oe  = active && (is_write || (bit_idx < TA_IDX));
  assign mdio_out = mdio_oe && tx_bit;

  // R2: line quiet and clock parked while idle
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && !mdio_out));

  // R6: driven value moves only with a falling MDC or a busy edge
  assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_out) || !$stable(mdio_oe)) |-> ($fell(mdc) || $rose(busy) || $fell(busy)));

  // R7: read result moves only together with done
  assert_rd_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);

  // R8: acceptance needs a request
  assert_accept_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int H   = 4;
  localparam int TXN = 2 * H * 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mdc, mdio_out, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_in = 1'b1;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // PHY: presents read data bits after MDC falling edges
  logic [15:0] phy_pat = '0;
  int fcnt = 0;
  always @(posedge busy) fcnt = 0;
  always @(negedge mdc) begin
    fcnt++;
    if (fcnt >= 48 && fcnt <= 63) mdio_in = phy_pat[63 - fcnt];
    else mdio_in = 1'b1;
  end

  function automatic logic [63:0] mk_frame(input bit w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b00), (w ? d : 16'h0)};
  endfunction

  // behavioural reference model
  bit m_busy = 0, m_done = 0, m_wr = 0;
  int m_t = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_rd = '0, m_acc = '0;
  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_rd = '0; m_acc = '0;
    end else if (m_busy) begin
      m_t++;
      if ((m_t % (2*H)) == H && !m_wr && (m_t / (2*H)) >= 48)
        m_acc = {m_acc[14:0], mdio_in};
      if (m_t == TXN) begin
        m_busy = 0; m_done = 1;
        if (!m_wr) m_rd = m_acc;
      end
    end else if (req_valid) begin
      m_busy = 1; m_t = 0; m_wr = req_write;
      m_frame = mk_frame(req_write, req_phy, req_reg, req_wdata);
    end
  end

  logic p_mdc = 0, p_out = 0, p_oe = 0, p_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      bit e_mdc, e_oe, e_out;
      string tg;
      k = m_t / (2*H);
      e_mdc = m_busy && ((m_t / H) % 2 == 1);
      e_oe  = m_busy && (m_wr || k < 46);
      e_out = e_oe && m_frame[63 - k];
      tg = !m_busy ? "R2" : (k < 46) ? "R3" : m_wr ? "R4" : "R5";
      chk(mdc == e_mdc, "R1 mdc", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, {tg, " oe"}, 32'(mdio_oe), 32'(e_oe));
      chk(mdio_out == e_out, {tg, " out"}, 32'(mdio_out), 32'(e_out));
      chk(busy == m_busy, "R8 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R8 done", 32'(done), 32'(m_done));
      chk(rd_data == m_rd, m_wr ? "R10 rd_data" : "R7 rd_data", 32'(rd_data), 32'(m_rd));
      if (mdio_out != p_out || mdio_oe != p_oe)
        chk((p_mdc && !mdc) || (p_busy != busy), "R6 drive change", {mdio_oe, mdio_out}, 32'h0);
      p_mdc = mdc; p_out = mdio_out; p_oe = mdio_oe; p_busy = busy;
    end
  end

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 4*TXN);
    chk(done === 1'b1, "R8 done seen", 32'(done), 32'h1);
  endtask

  task automatic send(input bit w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d, input logic [15:0] pat);
    @(negedge clk);
    phy_pat = pat;
    req_write = w; req_phy = p; req_reg = r; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({mdc, mdio_oe, mdio_out, busy, done} == 5'b0, "R11 reset outputs", 32'({mdc, mdio_oe, mdio_out, busy, done}), 32'h0);
    chk(rd_data == 16'h0, "R11 reset rd_data", 32'(rd_data), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4: plain write
    send(1, 5'h01, 5'h00, 16'hA5C3, 16'h0);
    wait_done();

    // R5 R7: read
    send(0, 5'h1F, 5'h12, 16'h0, 16'h8001);
    wait_done();
    chk(rd_data == 16'h8001, "R7 read value", 32'(rd_data), 32'h8001);

    // R9: requests during a write are ignored
    send(1, 5'h0A, 5'h15, 16'h3C5A, 16'h0);
    repeat (100) @(negedge clk);
    req_write = 1'b0; req_phy = 5'h11; req_reg = 5'h07; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    @(negedge clk);
    chk(busy == 1'b0, "R9 no extra transaction", 32'(busy), 32'h0);
    chk(rd_data == 16'h8001, "R10 rd_data after write", 32'(rd_data), 32'h8001);

    // R8: done and next acceptance back to back
    send(0, 5'h05, 5'h1E, 16'h0, 16'h6DB6);
    @(negedge clk);
    req_write = 1'b1; req_phy = 5'h02; req_reg = 5'h03; req_wdata = 16'hFFFF; req_valid = 1'b1;
    wait_done();
    chk(rd_data == 16'h6DB6, "R7 read value in done cycle", 32'(rd_data), 32'h6DB6);
    @(negedge clk);
    chk(busy == 1'b1, "R8 accept right after done", 32'(busy), 32'h1);
    req_valid = 1'b0;
    wait_done();
    chk(rd_data == 16'h6DB6, "R10 rd_data kept", 32'(rd_data), 32'h6DB6);

    // R7: all-zero read
    send(0, 5'h00, 5'h00, 16'h0, 16'h0000);
    wait_done();
    chk(rd_data == 16'h0000, "R7 zero read", 32'(rd_data), 32'h0);
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule